// File: doc/BRIEF.md
# Cache Block Pattern Compressor

This block packs one 128-byte cache block into a shorter run of 32-bit words before the block is written to memory. The block comes in as sixteen 64-bit doublewords on a valid/ready stream, after a one-cycle start pulse. Each doubleword is classified against a small set of bit patterns: all zero, zero upper half, equal halves, or zero lower half. Only the halves that carry information are emitted.

Two pattern codes are available, and they differ only in the meaning of encoding 10. The block picks one of them speculatively from tests on the first doubleword and applies it to the whole block. A running byte count is kept as doublewords arrive. When it exceeds the threshold, the block is abandoned as incompressible and sent out raw.

Once the whole block has been taken in, the compressed words stream out on a second valid/ready port. A one-cycle done pulse follows the last word. The metadata (block state, per-doubleword header and size field) is valid from the done pulse until the next start.

Top module: `blk_pattern_compressor`

## Requirements
- R1: The code is chosen from doubleword 0. If its upper and lower 32-bit halves are equal, code I is used. Otherwise, if their bitwise AND is zero, code II is used. Otherwise code I is used. The block state reads 00 for code I and 01 for code II.
- R2: Under code I each doubleword gets a 2-bit encoding and emits words as follows:
  - 00: the doubleword is zero; nothing is emitted.
  - 01: the upper half is zero; the lower half is emitted.
  - 10: the halves are equal; the lower half is emitted.
  - 11: both halves are emitted, upper first then lower.
  - Tests are applied in that order, and words follow doubleword order 0 to 15.
- R3: Code II is the same as code I except for encoding 10. Under code II, 10 means the lower half is zero and the upper half is emitted.
- R4: The 32-bit header holds the encoding of doubleword k in bits [31-2k : 30-2k], so doubleword 0 occupies bits 31:30.
- R5: The size field is the compressed byte count rounded up to a multiple of 8, expressed in units of 8 bytes. For example, 20 bytes gives 3.
- R6: The block is aborted when the running byte count exceeds 48; exactly 48 is still compressed. An aborted block reports:
  - state 10, header 0 and size 4'hF;
  - all 32 words, each doubleword upper half first.
- R7: A block of sixteen zero doublewords reports state 11, header 0 and size 0, and emits no words.
- R8: A stalled output word holds its value until it is accepted. Input and output are never active in the same cycle. Done is a single-cycle pulse that follows the last accepted word.
- R9: After reset, in_ready, out_valid and done are all low.
- R10: in_ready stays low until a start pulse arrives. A start pulse during a block in progress has no effect on that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new block when idle |
| in_valid | input | 1 | Input doubleword valid |
| in_ready | output | 1 | Block is accepting doublewords |
| in_data | input | 64 | Input doubleword, upper half in bits 63:32 |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 32 | Output word |
| done | output | 1 | One-cycle pulse after the block's last word |
| blk_state | output | 2 | 00 code I, 01 code II, 10 raw, 11 all zero |
| blk_header | output | 32 | Per-doubleword encodings, doubleword 0 in bits 31:30 |
| blk_size | output | 4 | Compressed size in 8-byte units, 4'hF when raw |

## Verification
The hardest situation to reach from the ports is the abort boundary, where the byte count lands exactly on 48 or one word past it. Reaching it needs a block whose doubleword patterns add up to a precise total under the code picked from doubleword 0. The stimulus table builds each block from a per-doubleword pattern kind, so the 48-byte and 52-byte blocks can be written down directly. Other vectors in the same table stall the output handshake, leave gaps in the input, and pulse start mid-block. A directed case also resets the block partway through loading.

// File: rtl/blk_pattern_compressor.sv
module blk_pattern_compressor #(
  parameter int DW        = 64,
  parameter int NDW       = 16,
  parameter int MAX_BYTES = 48,
  parameter int SZW       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DW-1:0]      in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DW/2-1:0]    out_data,
  output logic               done,
  output logic [1:0]         blk_state,
  output logic [2*NDW-1:0]   blk_header,
  output logic [SZW-1:0]     blk_size
);
  localparam int HW = DW / 2;
  localparam int IW = $clog2(NDW);
  localparam int BW = $clog2(NDW * DW / 8 + 1);
  localparam logic [BW-1:0] HALF_B = BW'(HW / 8);
  localparam logic [BW-1:0] FULL_B = BW'(DW / 8);
  localparam logic [BW-1:0] LIMIT  = BW'(MAX_BYTES);
  localparam logic [IW-1:0] LAST   = IW'(NDW - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_EMIT, S_FIN} st_t;

  st_t            st;
  logic [DW-1:0]  buf_q [NDW];
  logic [1:0]     enc_q [NDW];
  logic [IW-1:0]  idx;
  logic           half, alg2, abort_q;
  logic [BW-1:0]  bytes_q;

  wire [HW-1:0] in_hi = in_data[DW-1:HW];
  wire [HW-1:0] in_lo = in_data[HW-1:0];
  wire          pick2 = (idx == '0) ? (((in_hi ^ in_lo) != '0) && ((in_hi & in_lo) == '0)) : alg2;

  logic [1:0]    enc_in;
  logic [BW-1:0] add_b;
  always_comb begin
    if (in_data == '0)                  begin enc_in = 2'b00; add_b = '0;     end
    else if (in_hi == '0)               begin enc_in = 2'b01; add_b = HALF_B; end
    else if (!pick2 && in_hi == in_lo)  begin enc_in = 2'b10; add_b = HALF_B; end
    else if (pick2 && in_lo == '0)      begin enc_in = 2'b10; add_b = HALF_B; end
    else                                begin enc_in = 2'b11; add_b = FULL_B; end
  end

  wire [BW-1:0] bytes_nx = bytes_q + add_b;
  wire          in_fire  = in_valid && in_ready;

  wire [DW-1:0] cur     = buf_q[idx];
  wire [1:0]    cur_enc = abort_q ? 2'b11 : enc_q[idx];
  wire          last_w  = (cur_enc != 2'b11) || half;
  wire          out_fire = out_valid && out_ready;
  wire          step    = (st == S_EMIT) && ((cur_enc == 2'b00) || (out_ready && last_w));

  assign in_ready  = (st == S_LOAD);
  assign out_valid = (st == S_EMIT) && (cur_enc != 2'b00);
  assign done      = (st == S_FIN);

  always_comb begin
    case (cur_enc)
      2'b11:   out_data = half ? cur[HW-1:0] : cur[DW-1:HW];
      2'b10:   out_data = alg2 ? cur[DW-1:HW] : cur[HW-1:0];
      default: out_data = cur[HW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (in_fire) buf_q[idx] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      half    <= 1'b0;
      alg2    <= 1'b0;
      abort_q <= 1'b0;
      bytes_q <= '0;
      for (int i = 0; i < NDW; i++) enc_q[i] <= 2'b00;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_LOAD;
          idx     <= '0;
          half    <= 1'b0;
          abort_q <= 1'b0;
          bytes_q <= '0;
        end
        S_LOAD: if (in_fire) begin
          enc_q[idx] <= enc_in;
          bytes_q    <= bytes_nx;
          if (idx == '0) alg2 <= pick2;
          if (bytes_nx > LIMIT) abort_q <= 1'b1;
          if (idx == LAST) begin
            st  <= S_EMIT;
            idx <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_EMIT: begin
          if (out_fire && !last_w) half <= 1'b1;
          if (step) begin
            half <= 1'b0;
            if (idx == LAST) st <= S_FIN;
            else             idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [2*NDW-1:0] hdr_w;
  for (genvar g = 0; g < NDW; g++) begin : g_hdr
    assign hdr_w[2*(NDW-1-g) +: 2] = enc_q[g];
  end

  wire [BW-1:0] rnd_b = (bytes_q + BW'(7)) >> 3;

  assign blk_header = abort_q ? '0 : hdr_w;
  assign blk_state  = abort_q ? 2'b10 : (bytes_q == '0) ? 2'b11 : {1'b0, alg2};
  assign blk_size   = abort_q ? '1 : rnd_b[SZW-1:0];
endmodule

// File: rtl/blk_pattern_compressor_chk.sv
module blk_pattern_compressor_chk #(
  parameter int NDW       = 16,
  parameter int MAX_BYTES = 48,
  parameter int SZW       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic             done,
  input logic [1:0]       blk_state,
  input logic [2*NDW-1:0] blk_header,
  input logic [SZW-1:0]   blk_size
);
  logic [7:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (done) cnt <= '0;
    else if (out_valid && out_ready) cnt <= cnt + 8'd1;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RAW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done && blk_state == 2'b10 |-> cnt == 8'(2*NDW) && blk_size == '1 && blk_header == '0); // R6
  AST_PACKED_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    done && blk_state != 2'b10 |-> 8'((cnt + 8'd1) >> 1) == 8'(blk_size)); // R5
  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done && blk_state != 2'b10 |-> 8'(blk_size) <= 8'(MAX_BYTES / 8)); // R6
  AST_ZERO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done && blk_state == 2'b11 |-> cnt == 8'd0 && blk_header == '0); // R7
endmodule

bind blk_pattern_compressor blk_pattern_compressor_chk #(.NDW(NDW), .MAX_BYTES(MAX_BYTES), .SZW(SZW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .done(done),
  .blk_state(blk_state), .blk_header(blk_header), .blk_size(blk_size)
);

// File: tb/blk_pattern_compressor_tb.sv
module blk_pattern_compressor_tb;
  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, out_ready = 0;
  logic [63:0] in_data = '0;
  logic in_ready, out_valid, done;
  logic [31:0] out_data, blk_header;
  logic [1:0] blk_state;
  logic [3:0] blk_size;

  always #10 clk = ~clk;

  blk_pattern_compressor u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .blk_state(blk_state), .blk_header(blk_header), .blk_size(blk_size));

  int checks = 0, errors = 0;

  // kinds per doubleword (nibble, dw0 first): 0 zero, 1 upper zero, 2 equal halves, 3 lower zero, 4 full
  localparam int NV = 11;
  localparam logic [63:0] T_KIND [NV] = '{
    64'h2121_0000_3000_0001, 64'h3131_3000_0000_0000, 64'h4100_0000_0000_0000,
    64'h0000_0000_0000_0000, 64'h4444_4400_0000_0000, 64'h4444_4410_0000_0000,
    64'h4444_4444_4444_4444, 64'h0120_0000_0000_0002, 64'h3200_0000_0000_0000,
    64'h1000_0000_0000_0000, 64'h3333_3333_3333_3344 };
  localparam logic [7:0] T_SEED  [NV] = '{8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9, 8'd10, 8'd11};
  localparam logic [1:0] T_FLG   [NV] = '{2'b10, 2'b01, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00};
  localparam logic [1:0] T_STATE [NV] = '{2'b00, 2'b01, 2'b00, 2'b11, 2'b00, 2'b10, 2'b10, 2'b00, 2'b01, 2'b01, 2'b10};
  localparam logic [3:0] T_SIZE  [NV] = '{4'd4, 4'd3, 4'd2, 4'd0, 4'd6, 4'hF, 4'hF, 4'd2, 4'd2, 4'd1, 4'hF};

  logic [63:0] blk [16];
  logic [31:0] exp_w [32];
  logic [31:0] got_w [64];
  int exp_n, got_n;
  logic [31:0] exp_hdr;
  logic exp_ii;

  task automatic chk(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] k, input logic [7:0] s, input int i);
    logic [31:0] a, f;
    a = (32'h9E37_79B9 * 32'(int'(s) * 16 + i + 1)) | 32'h1;
    f = a | 32'h8000_0000;
    case (k)
      4'd0: mk = 64'h0;
      4'd1: mk = {32'h0, a};
      4'd2: mk = {a, a};
      4'd3: mk = {a, 32'h0};
      default: mk = {f, f ^ 32'h0F0F_0000};
    endcase
  endfunction

  task automatic model();
    int bytes;
    logic [31:0] hi, lo;
    bytes = 0; exp_n = 0; exp_hdr = '0;
    hi = blk[0][63:32]; lo = blk[0][31:0];
    exp_ii = ((hi ^ lo) != 0) && ((hi & lo) == 0);
    for (int i = 0; i < 16; i++) begin
      logic [1:0] e;
      hi = blk[i][63:32]; lo = blk[i][31:0];
      if (blk[i] == 0) e = 2'b00;
      else if (hi == 0) begin e = 2'b01; exp_w[exp_n++] = lo; end
      else if (!exp_ii && hi == lo) begin e = 2'b10; exp_w[exp_n++] = lo; end
      else if (exp_ii && lo == 0) begin e = 2'b10; exp_w[exp_n++] = hi; end
      else begin e = 2'b11; exp_w[exp_n++] = hi; exp_w[exp_n++] = lo; end
      exp_hdr[31-2*i -: 2] = e;
      bytes += (e == 2'b00) ? 0 : (e == 2'b11) ? 8 : 4;
    end
    if (bytes > 48) begin
      exp_hdr = '0; exp_n = 32;
      for (int i = 0; i < 16; i++) begin
        exp_w[2*i] = blk[i][63:32]; exp_w[2*i+1] = blk[i][31:0];
      end
    end
  endtask

  task automatic feed(input bit gaps, input int upto);
    int i = 0, cyc = 0;
    bit ok;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (i < upto) begin
      in_valid = !(gaps && cyc % 2 == 1);
      in_data = blk[i];
      ok = in_ready && in_valid;
      @(negedge clk);
      if (ok) i++;
      cyc++;
    end
    in_valid = 0;
  endtask

  task automatic run_vec(input int v);
    bit stall, poke, got_done;
    int cyc;
    string rq;
    stall = T_FLG[v][1]; poke = T_FLG[v][0];
    for (int i = 0; i < 16; i++) blk[i] = mk(T_KIND[v][63-4*i -: 4], T_SEED[v], i);
    model();
    feed(stall, 16);
    got_n = 0; got_done = 0; cyc = 0;
    while (!got_done && cyc < 400) begin
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      start = poke && (cyc == 2);
      if (out_valid && out_ready && got_n < 64) got_w[got_n++] = out_data;
      if (done) got_done = 1;
      else begin @(negedge clk); cyc++; end
    end
    start = 0;
    chk(got_done, "R8", $sformatf("vec %0d done seen", v), 64'(got_done), 64'd1);
    rq = (T_STATE[v] == 2'b10) ? "R6" : (T_STATE[v] == 2'b11) ? "R7" : "R1";
    chk(blk_state == T_STATE[v], rq, $sformatf("vec %0d state", v), 64'(blk_state), 64'(T_STATE[v]));
    chk(blk_size == T_SIZE[v], "R5", $sformatf("vec %0d size", v), 64'(blk_size), 64'(T_SIZE[v]));
    chk(blk_header == exp_hdr, "R4", $sformatf("vec %0d header", v), 64'(blk_header), 64'(exp_hdr));
    rq = (T_STATE[v] == 2'b10) ? "R6" : exp_ii ? "R3" : "R2";
    chk(got_n == exp_n, rq, $sformatf("vec %0d word count", v), 64'(got_n), 64'(exp_n));
    begin
      int bad = -1;
      for (int i = 0; i < exp_n && i < got_n; i++) if (bad < 0 && got_w[i] != exp_w[i]) bad = i;
      chk(bad < 0, rq, $sformatf("vec %0d word %0d", v, bad), (bad < 0) ? 64'h0 : 64'(got_w[bad]),
          (bad < 0) ? 64'h0 : 64'(exp_w[bad]));
    end
    @(negedge clk);
    chk(!done && !in_ready, poke ? "R10" : "R8", $sformatf("vec %0d after done", v), {62'h0, done, in_ready}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid && !done, "R9", "reset outputs", {61'h0, in_ready, out_valid, done}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk(!in_ready && !out_valid && !done, "R9", "idle after reset", {61'h0, in_ready, out_valid, done}, 64'h0);
    in_valid = 1; in_data = 64'h1234;
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid, "R10", "no load without start", {62'h0, in_ready, out_valid}, 64'h0);
    in_valid = 0;

    for (int v = 0; v < NV; v++) run_vec(v);

    // reset in the middle of loading, then a clean block
    for (int i = 0; i < 16; i++) blk[i] = mk(4'd4, 8'd33, i);
    feed(1'b0, 5);
    rst_n = 0;
    @(negedge clk);
    chk(!in_ready && !out_valid && !done, "R9", "reset mid block", {61'h0, in_ready, out_valid, done}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    run_vec(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule